// File: doc/BRIEF.md
# Bit-Sliced Mode-Selectable ALU

This block is a purely combinational arithmetic and logic unit built from a row of identical one-bit cells. Each cell sees one bit of each operand, a carry from the cell below, a mode line and two select lines. It returns one result bit and a carry for the cell above. The carry ripples from the least significant cell to the most significant one. The carry out of the last cell becomes the extra top bit of the result, so the result is one bit wider than the operands.

The mode line chooses between two families of operations. In logic mode the unit performs a bitwise operation and ignores the carry input. In arithmetic mode every cell acts as a full adder. The adder's first input is either the A bit or its complement. Its second input is either the B bit or zero. The carry input adds one to the sum.

This lets one select code give A, A+1, NOT A, NOT A + 1 (the negation of A), A+B, A+B+1, NOT A + B, and B minus A.

Top module: `slice_alu`

## Requirements
- R1: With mode=0 and sel=2'b00, res[7:0] equals a.
- R2: With mode=0 and sel=2'b01, res[7:0] equals the bitwise complement of a.
- R3: With mode=0 and sel=2'b10, res[7:0] equals a XOR b.
- R4: With mode=0 and sel=2'b11, res[7:0] equals the complement of (a XOR b).
- R5: With mode=0, res[8] is 0 and the result does not depend on cin.
- R6: With mode=1 and sel=2'b00, res equals a + cin, so 0xFF with cin=1 gives 9'h100.
- R7: With mode=1 and sel=2'b01, res equals (NOT a) + cin, so cin=1 gives the two's complement negation of a in res[7:0].
- R8: With mode=1 and sel=2'b10, res equals a + b + cin.
- R9: With mode=1, sel=2'b11 and cin=1, res[7:0] equals b - a modulo 256, and res[8] is 1 exactly when b >= a. With cin=0, res equals (NOT a) + b.
- R10: In arithmetic mode res[8] is the carry out of the most significant bit. The carry ripples through every cell, so a=0xFF, b=0x01, sel=2'b10, cin=0 gives 9'h100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry into the lowest cell (arithmetic mode only) |
| mode | input | 1 | 0 selects bitwise logic, 1 selects arithmetic |
| sel | input | 2 | Operation select; sel[1] enables b, sel[0] complements a |
| res | output | 9 | Result; bit 8 is the final carry out |

## Verification
Every one of the sixteen combinations of mode, cin and sel is applied to the edge operands 0x00, 0xFF and 0x80, in pairs with each other and with random operands.

- The 0xFF operands with a carry show that the carry travels the full length of the chain.
- The 0x80 operands expose a wrong top-cell carry.
- The pairs of operands that are equal or complementary separate XOR from XNOR and A from NOT A.
- In logic mode, running each code with both carry values shows whether the carry leaks into the result.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             mode,
  input  logic [1:0]       sel,
  output logic [WIDTH:0]   res
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic op_a, op_b, f_logic, f_arith;

    assign op_a    = a[i] ^ sel[0];
    assign op_b    = b[i] & sel[1];
    assign f_logic = sel[1] ? (a[i] ^ b[i] ^ sel[0]) : op_a;
    assign f_arith = op_a ^ op_b ^ carry[i];
    assign res[i]  = mode ? f_arith : f_logic;
    assign carry[i+1] = mode & ((op_a & op_b) | (carry[i] & (op_a ^ op_b)));
  end

  assign res[WIDTH] = carry[WIDTH];

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic             mode,
  input logic [1:0]       sel,
  input logic [WIDTH:0]   res
);

  logic [WIDTH:0] ref_sum;

  always_comb begin
    ref_sum = {1'b0, (sel[0] ? ~a : a)} + {1'b0, (sel[1] ? b : '0)} + {{WIDTH{1'b0}}, cin};
    if (!mode) begin
      // R5
      logic_carry_chk: assert (res[WIDTH] == 1'b0);
      if (sel == 2'b00) begin
        // R1
        pass_a_chk: assert (res[WIDTH-1:0] == a);
      end
      if (sel == 2'b01) begin
        // R2
        not_a_chk: assert (res[WIDTH-1:0] == ~a);
      end
      if (sel == 2'b10) begin
        // R3
        xor_op_chk: assert (res[WIDTH-1:0] == (a ^ b));
      end
      if (sel == 2'b11) begin
        // R4
        xnor_op_chk: assert (res[WIDTH-1:0] == ~(a ^ b));
      end
    end else begin
      // R8
      arith_sum_chk: assert (res == ref_sum);
      if (sel == 2'b11 && cin) begin
        // R9
        sub_ba_chk: assert (res[WIDTH-1:0] == WIDTH'(b - a) && res[WIDTH] == (b >= a));
      end
    end
  end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_slice_alu.sv
module test_slice_alu;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0, mode = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W:0]   res;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic [W:0] exp;
    logic [3:0] code;
  } item_t;

  item_t q[$];

  slice_alu #(.WIDTH(W)) i_slice_alu (
    .a(a), .b(b), .cin(cin), .mode(mode), .sel(sel), .res(res)
  );

  always #10 clk = ~clk;

  function automatic logic [W:0] model(logic [W-1:0] x, logic [W-1:0] y,
                                       logic c, logic m, logic [1:0] s);
    logic [W:0] r;
    if (!m) begin
      case (s)
        2'b00: r = {1'b0, x};
        2'b01: r = {1'b0, ~x};
        2'b10: r = {1'b0, x ^ y};
        default: r = {1'b0, ~(x ^ y)};
      endcase
    end else begin
      r = {1'b0, (s[0] ? ~x : x)} + {1'b0, (s[1] ? y : '0)} + {8'b0, c};
    end
    return r;
  endfunction

  function automatic string req_of(logic [3:0] code);
    case (code[2:0])
      3'b000: return "R1/R5";
      3'b001: return "R2/R5";
      3'b010: return "R3/R5";
      3'b011: return "R4/R5";
      3'b100: return "R6/R10";
      3'b101: return "R7/R10";
      3'b110: return "R8/R10";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic c, logic m, logic [1:0] s);
    item_t it;
    @(posedge clk);
    a <= x; b <= y; cin <= c; mode <= m; sel <= s;
    it.exp  = model(x, y, c, m, s);
    it.code = {c, m, s};
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (res !== it.exp) begin
        n_fail++;
        $display("FAIL %s: a=%h b=%h cin=%b mode=%b sel=%b actual=%h expected=%h",
                 req_of(it.code), a, b, cin, mode, sel, res, it.exp);
      end
    end
  end

  initial begin
    logic [W-1:0] edges[3];
    edges[0] = 8'h00; edges[1] = 8'hFF; edges[2] = 8'h80;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (res !== 9'h000) begin
      n_fail++;
      $display("FAIL R1: idle inputs actual=%h expected=%h", res, 9'h000);
    end
    for (int code = 0; code < 16; code++) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          drive(edges[i], edges[j], code[3], code[2], code[1:0]);
      for (int k = 0; k < 20; k++) begin
        logic [W-1:0] x;
        x = W'($urandom);
        drive(x, W'($urandom), code[3], code[2], code[1:0]);
        drive(x, x, code[3], code[2], code[1:0]);
        drive(x, ~x, code[3], code[2], code[1:0]);
      end
    end
    // R10 full ripple, R6 wrap, R9 equal operands
    drive(8'hFF, 8'h01, 1'b0, 1'b1, 2'b10);
    drive(8'hFF, 8'h00, 1'b1, 1'b1, 2'b00);
    drive(8'h42, 8'h42, 1'b1, 1'b1, 2'b11);
    drive(8'h43, 8'h42, 1'b1, 1'b1, 2'b11);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule